// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block chooses one reference input out of five candidate inputs for a timing path. An external monitor supplies a qualified flag for each candidate, and software supplies a 4-bit priority for each one. The block registers the chosen input's index, along with the indices of the three best qualified inputs in ranked order. Each index is reported as a 4-bit value where 0 means "none".

Two switching policies are available. In revertive mode the selection always follows the best qualified input. In non-revertive mode the active input is kept as long as it stays usable, even when a better input becomes qualified. A sticky flag records the moment the last usable input is lost. The flag is gated by an enable to form an interrupt, and a one-cycle pulse clears it.

Top module: `refsel_top`

## Requirements
- R1: Candidate k (k = 1..5) uses bit k-1 of `qual_i` and field `prio_i[4k-1:4k-4]`. A candidate is usable only when its qualified bit is 1 and its priority field is nonzero. Among usable candidates, a lower priority value ranks higher (1 is best, 15 is worst). Reported indices are k, with 0 meaning none.
- R2: Usable candidates with equal priority values are ordered by ascending index, for both selection and ranking.
- R3: `rank1_o`, `rank2_o` and `rank3_o` give the best, second and third usable candidates. Any rank position with no usable candidate reads 0, and no index appears in two rank positions.
- R4: While `revert_i` is 1, `sel_o` equals `rank1_o`.
- R5: While `revert_i` is 0 and the currently selected candidate stays usable, `sel_o` does not change, even when a better candidate becomes usable.
- R6: While `revert_i` is 0, if the selected candidate is no longer usable (or nothing is selected), `sel_o` takes the best usable candidate.
- R7: When no candidate is usable, `sel_o` and all rank outputs read 0.
- R8: `sel_o` and the rank outputs reflect the inputs present at the previous rising clock edge (one cycle of latency).
- R9: `lost_o` becomes 1 one cycle after an edge at which no candidate is usable, provided at least one was usable at the edge before. It then stays 1 until `lost_clr_i` is 1 at an edge. When a loss and a clear happen at the same edge, the loss wins.
- R10: `irq_o` is 1 exactly when `lost_o` is 1 and `irq_en_i` is 1.
- R11: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qual_i | input | 5 | Qualified flag per candidate (bit k-1 is candidate k) |
| prio_i | input | 20 | Priority per candidate, 4 bits each, 0 disables |
| revert_i | input | 1 | 1 = revertive switching, 0 = non-revertive |
| irq_en_i | input | 1 | Interrupt enable for the loss flag |
| lost_clr_i | input | 1 | Pulse that clears the sticky loss flag |
| sel_o | output | 4 | Index of the selected candidate, 0 when none |
| rank1_o | output | 4 | Best usable candidate index |
| rank2_o | output | 4 | Second-best usable candidate index |
| rank3_o | output | 4 | Third-best usable candidate index |
| lost_o | output | 1 | Sticky flag: all candidates lost |
| irq_o | output | 1 | Loss flag gated by the enable |

## Verification
The selection, the three ranks and the loss flag are each due one clock after the edge that samples the stimulus. `irq_o` follows the registered flag combinationally, using the enable applied in the same cycle. The bench changes inputs on the falling edge. Its reference model updates on the rising edge from those stable inputs, and every output is compared on the next falling edge, so each result is checked in exactly the cycle it is due. Directed sequences cover ties, disabled priorities, non-revertive holding and reselection, loss with and without the enable, and clear pulses. A long pseudo-random run follows the directed sequences.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned CAND_NUM = 5;
  localparam int unsigned PRIO_W   = 4;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned RANK_NUM = 3;
endpackage

// File: rtl/refsel_rank.sv
// Combinational ordering of usable candidates: a candidate's position is the
// number of usable candidates that beat it (lower priority, or equal priority
// at a lower index).
module refsel_rank #(
  parameter int unsigned N  = 5,
  parameter int unsigned PW = 4,
  parameter int unsigned IW = 4,
  parameter int unsigned NR = 3
) (
  input  logic [N-1:0]     usable,
  input  logic [N*PW-1:0]  prio,
  output logic [NR*IW-1:0] rank_idx
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] beat_cnt [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      beat_cnt[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && usable[j]) begin
          if ((prio[j*PW +: PW] < prio[i*PW +: PW]) ||
              ((prio[j*PW +: PW] == prio[i*PW +: PW]) && (j < i))) begin
            beat_cnt[i] = beat_cnt[i] + 1'b1;
          end
        end
      end
    end
  end

  generate
    for (genvar k = 0; k < NR; k++) begin : g_pos
      always_comb begin
        rank_idx[k*IW +: IW] = '0;
        for (int i = 0; i < N; i++) begin
          if (usable[i] && (beat_cnt[i] == CW'(k))) begin
            rank_idx[k*IW +: IW] = IW'(i + 1);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/refsel_hold.sv
// Selection register with revertive / non-revertive policy.
module refsel_hold #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          revert,
  input  logic [N-1:0]  usable,
  input  logic [IW-1:0] best,
  output logic [IW-1:0] sel_q
);
  logic          cur_ok;
  logic [IW-1:0] sel_d;
  logic          sel_en;

  always_comb begin
    cur_ok = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_q == IW'(i + 1)) begin
        cur_ok = usable[i];
      end
    end
  end

  always_comb begin
    if (!revert && cur_ok) begin
      sel_d = sel_q;
    end else begin
      sel_d = best;
    end
    sel_en = (sel_d != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/refsel_loss.sv
// Sticky "all candidates lost" flag with gated interrupt.
module refsel_loss (
  input  logic clk,
  input  logic rst_n,
  input  logic any_usable,
  input  logic clr,
  input  logic irq_en,
  output logic lost_q,
  output logic irq
);
  logic had_q;
  logic lost_d;
  logic had_en;
  logic lost_en;

  always_comb begin
    if (had_q && !any_usable) begin
      lost_d = 1'b1;
    end else if (clr) begin
      lost_d = 1'b0;
    end else begin
      lost_d = lost_q;
    end
    lost_en = (lost_d != lost_q);
    had_en  = (had_q != any_usable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= 1'b0;
    end else if (lost_en) begin
      lost_q <= lost_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      had_q <= 1'b0;
    end else if (had_en) begin
      had_q <= any_usable;
    end
  end

  assign irq = lost_q & irq_en;
endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
  parameter int unsigned N  = refsel_pkg::CAND_NUM,
  parameter int unsigned PW = refsel_pkg::PRIO_W,
  parameter int unsigned IW = refsel_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  qual_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic          revert_i,
  input  logic          irq_en_i,
  input  logic          lost_clr_i,
  output logic [IW-1:0] sel_o,
  output logic [IW-1:0] rank1_o,
  output logic [IW-1:0] rank2_o,
  output logic [IW-1:0] rank3_o,
  output logic          lost_o,
  output logic          irq_o
);
  localparam int unsigned NR = refsel_pkg::RANK_NUM;

  logic [N-1:0]     usable;
  logic [NR*IW-1:0] rank_d;
  logic [NR*IW-1:0] rank_q;
  logic             rank_en;

  generate
    for (genvar i = 0; i < N; i++) begin : g_use
      assign usable[i] = qual_i[i] & (prio_i[i*PW +: PW] != '0);
    end
  endgenerate

  refsel_rank #(.N(N), .PW(PW), .IW(IW), .NR(NR)) u_rank (
    .usable   (usable),
    .prio     (prio_i),
    .rank_idx (rank_d)
  );

  assign rank_en = (rank_d != rank_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= '0;
    end else if (rank_en) begin
      rank_q <= rank_d;
    end
  end

  refsel_hold #(.N(N), .IW(IW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .revert (revert_i),
    .usable (usable),
    .best   (rank_d[IW-1:0]),
    .sel_q  (sel_o)
  );

  refsel_loss u_loss (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_usable (|usable),
    .clr        (lost_clr_i),
    .irq_en     (irq_en_i),
    .lost_q     (lost_o),
    .irq        (irq_o)
  );

  assign rank1_o = rank_q[0*IW +: IW];
  assign rank2_o = rank_q[1*IW +: IW];
  assign rank3_o = rank_q[2*IW +: IW];
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk #(
  parameter int unsigned N  = 5,
  parameter int unsigned PW = 4,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  qual_i,
  input logic [N*PW-1:0] prio_i,
  input logic          revert_i,
  input logic          lost_clr_i,
  input logic [IW-1:0] sel_o,
  input logic [IW-1:0] rank1_o,
  input logic [IW-1:0] rank2_o,
  input logic          lost_o,
  input logic          irq_o
);
  logic [N-1:0] ok_vec;
  logic         sel_live;

  always_comb begin
    sel_live = 1'b0;
    for (int i = 0; i < N; i++) begin
      ok_vec[i] = qual_i[i] && (prio_i[i*PW +: PW] != '0);
      if (sel_o == IW'(i + 1)) begin
        sel_live = ok_vec[i];
      end
    end
  end

  // R4
  rev_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    revert_i |=> (sel_o == rank1_o));

  // R5
  nonrev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!revert_i && sel_live) |=> (sel_o == $past(sel_o)));

  // R7
  none_usable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_vec == '0) |=> (sel_o == '0 && rank1_o == '0));

  // R3
  rank_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rank2_o != '0) |-> (rank1_o != '0 && rank1_o != rank2_o));

  // R9
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && !lost_clr_i) |=> lost_o);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> lost_o);
endmodule

bind refsel_top refsel_chk #(.N(N), .PW(PW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .qual_i     (qual_i),
  .prio_i     (prio_i),
  .revert_i   (revert_i),
  .lost_clr_i (lost_clr_i),
  .sel_o      (sel_o),
  .rank1_o    (rank1_o),
  .rank2_o    (rank2_o),
  .lost_o     (lost_o),
  .irq_o      (irq_o)
);

// File: tb/test_refsel_top.sv
module test_refsel_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int PW = 4;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  qual;
  logic [N*PW-1:0] prio;
  logic          revert, irq_en, lost_clr;
  logic [IW-1:0] sel, r1, r2, r3;
  logic          lost, irq;

  int checks = 0;
  int errors = 0;

  int m_sel, m_r1, m_r2, m_r3, m_lost, m_had;

  always #(CLK_PERIOD/2) clk = ~clk;

  refsel_top i_refsel_top (
    .clk(clk), .rst_n(rst_n), .qual_i(qual), .prio_i(prio),
    .revert_i(revert), .irq_en_i(irq_en), .lost_clr_i(lost_clr),
    .sel_o(sel), .rank1_o(r1), .rank2_o(r2), .rank3_o(r3),
    .lost_o(lost), .irq_o(irq)
  );

  // Pick the (k+1)-th best usable candidate by repeated minimum search.
  function automatic int ref_pick(logic [N-1:0] q, logic [N*PW-1:0] p, int k);
    bit taken [N];
    int pick = 0;
    for (int i = 0; i < N; i++) taken[i] = 0;
    for (int s = 0; s <= k; s++) begin
      int bi = -1;
      int bp = 1 << PW;
      for (int i = 0; i < N; i++) begin
        if (!taken[i] && q[i] && p[i*PW +: PW] != 0 && int'(p[i*PW +: PW]) < bp) begin
          bi = i;
          bp = int'(p[i*PW +: PW]);
        end
      end
      if (bi < 0) return 0;
      taken[bi] = 1;
      pick = bi + 1;
    end
    return pick;
  endfunction

  function automatic logic [N*PW-1:0] pk(int a, int b, int c, int d, int e);
    return {4'(e), 4'(d), 4'(c), 4'(b), 4'(a)};
  endfunction

  // Reference model, updated on the rising edge from stable inputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_r1 = 0; m_r2 = 0; m_r3 = 0; m_lost = 0; m_had = 0;
    end else begin
      int best;
      int any;
      int cur_ok;
      best = ref_pick(qual, prio, 0);
      any = (best != 0);
      cur_ok = 0;
      if (m_sel != 0) cur_ok = qual[m_sel-1] && (prio[(m_sel-1)*PW +: PW] != 0);
      if (revert || !cur_ok) m_sel = best;
      m_r1 = best;
      m_r2 = ref_pick(qual, prio, 1);
      m_r3 = ref_pick(qual, prio, 2);
      if (m_had && !any) m_lost = 1;
      else if (lost_clr) m_lost = 0;
      m_had = any;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1 R2 R4 R5 R6 R7 R8 sel", int'(sel), m_sel);
    check("R1 R2 R3 R7 R8 rank1", int'(r1), m_r1);
    check("R2 R3 rank2", int'(r2), m_r2);
    check("R2 R3 rank3", int'(r3), m_r3);
    check("R9 lost", int'(lost), m_lost);
    check("R10 irq", int'(irq), m_lost & int'(irq_en));
  endtask

  task automatic apply(logic [N-1:0] q, logic [N*PW-1:0] p, logic rv, logic en, logic clr);
    qual = q; prio = p; revert = rv; irq_en = en; lost_clr = clr;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    qual = '1; prio = pk(1, 2, 3, 4, 5); revert = 1'b1; irq_en = 1'b1; lost_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs idle during reset
    check("R11 reset sel", int'(sel), 0);
    check("R11 reset rank1", int'(r1), 0);
    check("R11 reset lost", int'(lost), 0);
    check("R11 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    qual = '0;
    @(negedge clk);
    compare_all();

    // R1 R4: revertive, distinct priorities -> 4,2,1
    apply(5'b11111, pk(5, 3, 7, 2, 9), 1'b1, 1'b1, 1'b0);
    check("R1 rank order", int'(r1) * 100 + int'(r2) * 10 + int'(r3), 421);
    // R2: all equal -> 1,2,3
    apply(5'b11111, pk(3, 3, 3, 3, 3), 1'b1, 1'b1, 1'b0);
    check("R2 tie order", int'(r1) * 100 + int'(r2) * 10 + int'(r3), 123);
    // R1: priority 0 disables -> 2,4,5
    apply(5'b11111, pk(0, 1, 0, 2, 2), 1'b1, 1'b1, 1'b0);
    check("R1 disabled skipped", int'(r1) * 100 + int'(r2) * 10 + int'(r3), 245);
    // R3: only one usable -> others 0
    apply(5'b00100, pk(1, 1, 6, 1, 1), 1'b1, 1'b1, 1'b0);
    check("R3 empty ranks", int'(r1) * 100 + int'(r2) * 10 + int'(r3), 300);

    // R5 R6: non-revertive hold then reselect
    apply(5'b00001, pk(4, 2, 3, 1, 1), 1'b0, 1'b1, 1'b0);
    apply(5'b00001, pk(4, 2, 3, 1, 1), 1'b0, 1'b1, 1'b0);
    check("R6 sel first", int'(sel), 1);
    apply(5'b11111, pk(4, 2, 3, 1, 1), 1'b0, 1'b1, 1'b0);
    check("R5 hold sel", int'(sel), 1);
    check("R5 rank1 differs", int'(r1), 4);
    apply(5'b11110, pk(4, 2, 3, 1, 1), 1'b0, 1'b1, 1'b0);
    check("R6 reselect", int'(sel), 4);
    // R4: back to revertive
    apply(5'b11110, pk(4, 9, 3, 5, 1), 1'b1, 1'b1, 1'b0);
    check("R4 revert best", int'(sel), 5);

    // R7 R9 R10: all lost with enable
    apply(5'b00000, pk(4, 9, 3, 5, 1), 1'b1, 1'b1, 1'b0);
    check("R7 none sel", int'(sel), 0);
    check("R9 lost set", int'(lost), 1);
    check("R10 irq on", int'(irq), 1);
    apply(5'b00000, pk(4, 9, 3, 5, 1), 1'b1, 1'b0, 1'b0);
    check("R10 irq masked", int'(irq), 0);
    apply(5'b00010, pk(4, 9, 3, 5, 1), 1'b1, 1'b1, 1'b0);
    check("R9 sticky after recovery", int'(lost), 1);
    apply(5'b00010, pk(4, 9, 3, 5, 1), 1'b1, 1'b1, 1'b1);
    check("R9 cleared", int'(lost), 0);
    apply(5'b00010, pk(0, 0, 0, 0, 0), 1'b1, 1'b1, 1'b1);
    check("R9 loss beats clear", int'(lost), 1);
    apply(5'b00000, pk(0, 0, 0, 0, 0), 1'b1, 1'b1, 1'b0);

    // Pseudo-random run
    for (int c = 0; c < 1500; c++) begin
      logic [N-1:0] q;
      logic [N*PW-1:0] p;
      q = N'($urandom);
      if ($urandom_range(0, 7) == 0) q = '0;
      p = (c % 20 < 10) ? prio : (N*PW)'($urandom);
      if ($urandom_range(0, 3) == 0) p = (N*PW)'($urandom);
      apply(q, p, 1'($urandom_range(0, 2) == 0), 1'($urandom),
            1'($urandom_range(0, 5) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule